// File: doc/BRIEF.md
# Cascade Member Configuration and Fill-Chain Slice

This block is the configuration and priority-chain controller that sits inside every member of a vertical cascade of content-addressable memory devices. All members share one bus. A write cycle with the instruction-select pin high loads an opcode. A write cycle with instruction-select low then runs the held opcode on the data word. The slice holds a 32-bit configuration word, a control-mode bit and a fill flag.

A configuration write goes to every member at once. A page-address write reaches every member, but only the first member in the priority chain whose fill flag is clear takes it. That member copies the low four data bits into the page field of its configuration word and sets its own fill flag. The next page-address write therefore falls through to the member below. A fill-flag reset instruction clears the flag in every member, and the cascade is then ready for normal use. Each member gets `chain_in` from the member above it and drives `chain_out` to the member below. The top member has `chain_in` tied high.

Top module: `cam_cfg_slice`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it is released, `cfg_word` equals the value with only bit 25 set, `filled` is 0 and `hw_ctrl` is 0 (software control).
- R2: An instruction cycle (`wr`=1, `ins_sel`=1) with `bus_d[11:0]`=0x006 arms a configuration write. In each later data cycle (`wr`=1, `ins_sel`=0), all 32 bits of `bus_d` go into `cfg_word` one clock later.
- R3: A configuration write sets `hw_ctrl` to 1 when data bits 27:26 are 00, and to 0 otherwise.
- R4: An instruction cycle with opcode 0x00E arms a page-address write. A data cycle with `chain_in`=1 and `filled`=0 replaces `cfg_word[3:0]` with `bus_d[3:0]`, keeps bits 31:4, and sets `filled` to 1 one clock later.
- R5: An armed page-address data cycle with `chain_in`=0 or `filled`=1 leaves `cfg_word`, `filled` and `hw_ctrl` unchanged.
- R6: An instruction cycle with opcode 0x01C clears `filled` and leaves `cfg_word` and `hw_ctrl` unchanged.
- R7: An instruction cycle with opcode 0x000 (software reset) puts the slice into the R1 state one clock later.
- R8: `chain_out` is 1 exactly when `filled` and `chain_in` are both 1, with no clock delay.
- R9: A data cycle with nothing armed changes nothing. Nothing is armed after a reset, or after an instruction cycle with any opcode other than 0x006 or 0x00E. A cycle with `wr`=0 also changes nothing.
- R10: An armed opcode stays in force over any number of data cycles. It is replaced only by the next instruction cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| bus_d | input | 32 | Shared bus: opcode in bits 11:0 on instruction cycles, data word on data cycles |
| ins_sel | input | 1 | 1 = instruction cycle, 0 = data cycle |
| wr | input | 1 | 1 = write cycle; 0 = idle |
| chain_in | input | 1 | 1 when every higher-priority member is filled (tie high at the top member) |
| cfg_word | output | 32 | Configuration word |
| filled | output | 1 | Fill flag, 1 = filled |
| hw_ctrl | output | 1 | Control mode, 1 = hardware control |
| chain_out | output | 1 | Fill status passed to the next lower-priority member |

## Verification
The bench builds the slice with its default parameters: a 32-bit word, a 12-bit opcode field, a 4-bit page field at bit 0, the mode field at bits 27:26, the lowest-priority marker at bit 25, and opcodes 0x006, 0x00E, 0x01C and 0x000. With these values the bench can reach opcode collisions in random opcodes and page writes that are refused for each of the two reasons. It can also reach configuration words that sit on both sides of the mode decode, and software resets issued while a page write is armed.

// File: rtl/cfg_slice_pkg.sv
package cfg_slice_pkg;

  // Kind of operation held armed between instruction and data cycles
  typedef enum logic [1:0] {
    ARM_NONE = 2'd0,
    ARM_CFG  = 2'd1,
    ARM_PAGE = 2'd2
  } arm_kind_e;

  // Per-cycle events produced by the command decoder
  typedef struct packed {
    logic ld_cfg;   // data cycle under an armed configuration write
    logic ld_page;  // data cycle under an armed page-address write
    logic clr_fill; // fill-flag reset instruction
    logic sw_rst;   // software reset instruction
  } slice_ev_t;

endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_slice_pkg::*;
#(
  parameter int              INS_W    = 12,
  parameter logic [INS_W-1:0] OP_WRCFG = 'h006,
  parameter logic [INS_W-1:0] OP_WRPG  = 'h00E,
  parameter logic [INS_W-1:0] OP_CLRFF = 'h01C,
  parameter logic [INS_W-1:0] OP_SWRST = 'h000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INS_W-1:0] opcode,
  input  logic             ins_sel,
  input  logic             wr,
  output slice_ev_t        ev,
  output arm_kind_e        armed
);

  logic      ins_cyc;
  logic      dat_cyc;
  arm_kind_e armed_q;
  arm_kind_e armed_nx;

  assign ins_cyc = wr & ins_sel;
  assign dat_cyc = wr & ~ins_sel;

  // Classify an opcode into the kind of data-cycle work it arms
  function automatic arm_kind_e classify(input logic [INS_W-1:0] op);
    if (op == OP_WRCFG)     return ARM_CFG;
    else if (op == OP_WRPG) return ARM_PAGE;
    else                    return ARM_NONE;
  endfunction

  always_comb begin
    armed_nx = armed_q;
    if (ins_cyc) armed_nx = classify(opcode);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= ARM_NONE;
    else        armed_q <= armed_nx;
  end

  always_comb begin
    ev          = '0;
    ev.ld_cfg   = dat_cyc && (armed_q == ARM_CFG);
    ev.ld_page  = dat_cyc && (armed_q == ARM_PAGE);
    ev.clr_fill = ins_cyc && (opcode == OP_CLRFF);
    ev.sw_rst   = ins_cyc && (opcode == OP_SWRST);
  end

  assign armed = armed_q;

endmodule

// File: rtl/cfg_word_reg.sv
module cfg_word_reg #(
  parameter int DATA_W     = 32,
  parameter int PAGE_W     = 4,
  parameter int PAGE_LSB   = 0,
  parameter int MODE_LSB   = 26,
  parameter int MODE_W     = 2,
  parameter int LOWPRI_BIT = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              ld_cfg,
  input  logic              pg_take,
  input  logic [DATA_W-1:0] bus_d,
  output logic [DATA_W-1:0] cfg_q,
  output logic              hw_q
);

  localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] CFG_RST = ONE << LOWPRI_BIT;

  // Bit mask of the page field, built per bit
  logic [DATA_W-1:0] page_mask;
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign page_mask[b] = (b >= PAGE_LSB) && (b < PAGE_LSB + PAGE_W);
  end

  function automatic logic [DATA_W-1:0] page_merge(
    input logic [DATA_W-1:0] cur, input logic [DATA_W-1:0] src,
    input logic [DATA_W-1:0] msk);
    return (cur & ~msk) | ((src << PAGE_LSB) & msk);
  endfunction

  function automatic logic mode_is_hw(input logic [DATA_W-1:0] w);
    return w[MODE_LSB +: MODE_W] == '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || sw_rst) begin
      cfg_q <= CFG_RST;
      hw_q  <= 1'b0;
    end else if (ld_cfg) begin
      cfg_q <= bus_d;
      hw_q  <= mode_is_hw(bus_d);
    end else if (pg_take) begin
      cfg_q <= page_merge(cfg_q, bus_d, page_mask);
    end
  end

endmodule

// File: rtl/cfg_fill_link.sv
module cfg_fill_link (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic clr_fill,
  input  logic ld_page,
  input  logic chain_in,
  output logic pg_take,
  output logic pg_skip,
  output logic fill_q,
  output logic chain_out
);

  logic first_empty;

  assign first_empty = chain_in & ~fill_q;
  assign pg_take     = ld_page & first_empty;
  assign pg_skip     = ld_page & ~first_empty;
  assign chain_out   = fill_q & chain_in;

  always_ff @(posedge clk) begin
    if (!rst_n || sw_rst || clr_fill) fill_q <= 1'b0;
    else if (pg_take)                 fill_q <= 1'b1;
  end

endmodule

// File: rtl/cam_cfg_slice.sv
module cam_cfg_slice
  import cfg_slice_pkg::*;
#(
  parameter int               DATA_W     = 32,
  parameter int               INS_W      = 12,
  parameter int               PAGE_W     = 4,
  parameter int               PAGE_LSB   = 0,
  parameter int               MODE_LSB   = 26,
  parameter int               MODE_W     = 2,
  parameter int               LOWPRI_BIT = 25,
  parameter logic [INS_W-1:0] OP_WRCFG   = 'h006,
  parameter logic [INS_W-1:0] OP_WRPG    = 'h00E,
  parameter logic [INS_W-1:0] OP_CLRFF   = 'h01C,
  parameter logic [INS_W-1:0] OP_SWRST   = 'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_d,
  input  logic              ins_sel,
  input  logic              wr,
  input  logic              chain_in,
  output logic [DATA_W-1:0] cfg_word,
  output logic              filled,
  output logic              hw_ctrl,
  output logic              chain_out
);

  slice_ev_t ev;
  arm_kind_e armed;
  logic      pg_take;
  logic      pg_skip;

  cfg_cmd_decode #(
    .INS_W(INS_W), .OP_WRCFG(OP_WRCFG), .OP_WRPG(OP_WRPG),
    .OP_CLRFF(OP_CLRFF), .OP_SWRST(OP_SWRST)
  ) dec_i (
    .clk(clk), .rst_n(rst_n), .opcode(bus_d[INS_W-1:0]),
    .ins_sel(ins_sel), .wr(wr), .ev(ev), .armed(armed)
  );

  cfg_fill_link fill_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(ev.sw_rst), .clr_fill(ev.clr_fill),
    .ld_page(ev.ld_page), .chain_in(chain_in), .pg_take(pg_take),
    .pg_skip(pg_skip), .fill_q(filled), .chain_out(chain_out)
  );

  cfg_word_reg #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB),
    .MODE_LSB(MODE_LSB), .MODE_W(MODE_W), .LOWPRI_BIT(LOWPRI_BIT)
  ) word_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(ev.sw_rst), .ld_cfg(ev.ld_cfg),
    .pg_take(pg_take), .bus_d(bus_d), .cfg_q(cfg_word), .hw_q(hw_ctrl)
  );

endmodule

// File: rtl/cfg_slice_chk.sv
module cfg_slice_chk #(
  parameter int DATA_W     = 32,
  parameter int PAGE_W     = 4,
  parameter int PAGE_LSB   = 0,
  parameter int MODE_LSB   = 26,
  parameter int MODE_W     = 2,
  parameter int LOWPRI_BIT = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_d,
  input logic              wr,
  input logic              chain_in,
  input logic [DATA_W-1:0] cfg_word,
  input logic              filled,
  input logic              hw_ctrl,
  input logic              chain_out,
  input logic              ld_cfg,
  input logic              pg_take,
  input logic              pg_skip,
  input logic              clr_fill,
  input logic              sw_rst
);

  localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] CFG_RST = ONE << LOWPRI_BIT;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_word == CFG_RST) && !filled && !hw_ctrl);

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cfg && !sw_rst |=> cfg_word == $past(bus_d));

  // R3
  mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cfg |=> hw_ctrl == ($past(bus_d[MODE_LSB +: MODE_W]) == '0));

  // R4
  page_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_take |=> filled && (cfg_word[PAGE_LSB +: PAGE_W] == $past(bus_d[PAGE_W-1:0])));

  // R5
  page_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_skip |=> $stable(cfg_word) && $stable(filled) && $stable(hw_ctrl));

  // R6
  fill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fill |=> !filled && $stable(cfg_word));

  // R7
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (cfg_word == CFG_RST) && !filled && !hw_ctrl);

  // R8
  chain_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_out |-> filled && chain_in);

  // R8
  chain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filled && chain_in) |-> chain_out);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg_word) && $stable(filled) && $stable(hw_ctrl));

endmodule

bind cam_cfg_slice cfg_slice_chk #(
  .DATA_W(DATA_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB),
  .MODE_LSB(MODE_LSB), .MODE_W(MODE_W), .LOWPRI_BIT(LOWPRI_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .wr(wr), .chain_in(chain_in),
  .cfg_word(cfg_word), .filled(filled), .hw_ctrl(hw_ctrl),
  .chain_out(chain_out), .ld_cfg(ev.ld_cfg), .pg_take(pg_take),
  .pg_skip(pg_skip), .clr_fill(ev.clr_fill), .sw_rst(ev.sw_rst)
);

// File: tb/cam_cfg_slice_tb_top.sv
module cam_cfg_slice_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] O_CFG = 12'h006, O_PG = 12'h00E,
                          O_CLR = 12'h01C, O_RST = 12'h000;
  localparam logic [31:0] RST_WORD = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_d = '0;
  logic        ins_sel = 1'b0, wr = 1'b0, chain_in = 1'b0;
  logic [31:0] cfg_word;
  logic        filled, hw_ctrl, chain_out;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model: 0 none, 1 config, 2 page
  logic [31:0] m_cfg;
  logic        m_fill, m_hw;
  int          m_arm;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_cfg_slice dut_i (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .ins_sel(ins_sel), .wr(wr),
    .chain_in(chain_in), .cfg_word(cfg_word), .filled(filled),
    .hw_ctrl(hw_ctrl), .chain_out(chain_out)
  );

  function automatic logic hw_of(input logic [31:0] w);
    return (w[27] | w[26]) == 1'b0;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cfg = RST_WORD; m_fill = 0; m_hw = 0; m_arm = 0;
  endtask

  task automatic model_step(input logic r, input logic i, input logic w,
                            input logic [31:0] d, input logic ci);
    if (!r) model_reset();
    else if (w && i) begin
      if (d[11:0] == O_RST) model_reset();
      else begin
        if (d[11:0] == O_CLR) m_fill = 0;
        m_arm = (d[11:0] == O_CFG) ? 1 : (d[11:0] == O_PG) ? 2 : 0;
      end
    end else if (w) begin
      if (m_arm == 1) begin m_cfg = d; m_hw = hw_of(d); end
      else if (m_arm == 2 && ci && !m_fill) begin
        m_cfg = {m_cfg[31:4], d[3:0]}; m_fill = 1;
      end
    end
  endtask

  task automatic cyc(input logic r, input logic i, input logic w,
                     input logic [31:0] d, input logic ci, input string tag);
    @(negedge clk);
    rst_n = r; ins_sel = i; wr = w; bus_d = d; chain_in = ci;
    #1;
    check(chain_out == (m_fill & ci), "R8 chain_out", {31'd0, chain_out},
          {31'd0, m_fill & ci});
    @(posedge clk);
    model_step(r, i, w, d, ci);
    #1;
    check(cfg_word == m_cfg, {tag, " cfg_word"}, cfg_word, m_cfg);
    check(filled == m_fill, {tag, " filled"}, {31'd0, filled}, {31'd0, m_fill});
    check(hw_ctrl == m_hw, {tag, " hw_ctrl"}, {31'd0, hw_ctrl}, {31'd0, m_hw});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    cyc(0, 0, 0, '0, 1, "R1 in reset");
    cyc(1, 0, 0, '0, 1, "R1 after release");
    cyc(1, 0, 1, 32'hFFFF_FFFF, 1, "R9 unarmed data");
    cyc(1, 1, 1, {20'h0, O_CFG}, 1, "R2 arm cfg");
    cyc(1, 0, 1, 32'h1234_5678, 1, "R2 R3 cfg mode00");
    cyc(1, 0, 1, 32'h0400_00A0, 1, "R10 R3 cfg repeat mode01");
    cyc(1, 0, 0, 32'hDEAD_BEEF, 1, "R9 idle");
    cyc(1, 1, 1, {20'h0, O_PG}, 1, "R4 arm page");
    cyc(1, 0, 1, 32'h0000_0007, 0, "R5 page chain_in low");
    cyc(1, 0, 1, 32'hFFFF_FFF5, 1, "R4 page take");
    cyc(1, 0, 1, 32'h0000_0003, 1, "R5 R10 page already filled");
    cyc(1, 1, 1, {20'h0, O_CLR}, 0, "R6 clear fill");
    cyc(1, 0, 1, 32'h0000_0009, 1, "R9 after clear");
    cyc(1, 1, 1, {20'h0, O_PG}, 1, "R4 rearm");
    cyc(1, 0, 1, 32'h0000_000C, 1, "R4 second take");
    cyc(1, 0, 0, '0, 1, "R8 filled pass");
    cyc(1, 1, 1, {20'h0, O_RST}, 1, "R7 soft reset");
    cyc(1, 0, 1, 32'h0000_0001, 1, "R9 after soft reset");
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] d;
      logic [2:0]  k;
      logic        r, i, w, ci;
      d  = $urandom;
      k  = 3'($urandom_range(0, 7));
      r  = ($urandom_range(0, 199) != 0);
      w  = ($urandom_range(0, 5) != 0);
      i  = ($urandom_range(0, 2) == 0);
      ci = ($urandom_range(0, 3) != 0);
      if (i) begin
        case (k)
          0, 1: d[11:0] = O_CFG;
          2, 3: d[11:0] = O_PG;
          4:    d[11:0] = O_CLR;
          5:    d[11:0] = O_RST;
          default: ;
        endcase
      end
      cyc(r, i, w, d, ci, !r ? "R1 rnd" : i ? "R6 R7 R10 rnd"
                          : w ? "R2 R4 R5 rnd" : "R9 rnd");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule